// File: doc/BRIEF.md
# Debounced Level-Sensitive Interrupt Bank

This block watches sixteen input-only lines and turns each one into a level-type interrupt source. Every line first passes through a two-flop synchroniser. Software then chooses an active polarity for the line and starts a debounce window by writing to an arm register. When the window ends, the synchronised level is compared with the chosen polarity. If they match, a sticky raw status bit is set. Raw status ANDed with a per-line enable forms the pending status, and the OR of all pending bits drives one registered interrupt output.

The hardware only detects levels. Software gets edge behaviour by inverting a line's polarity after each event and arming the line again. A prescaler turns the core clock into a millisecond tick, and each line has a 12-bit debounce field counted in those ticks. Registers are reached through a simple word-addressed port. A write strobe or a read strobe is sampled on the same edge as the address and the 16-bit data. Read data returns on the next cycle.

Top module: `lvl_irq_bank`

## Requirements
- R1: Word addresses are fixed as follows: VIEW=0, VIEW_EN=1, POL=5, IRQ_EN=6, RAW=7, PEND=8, CLR=9, ARM=10, and the config word of line n sits at 16+n. After reset every register reads 0 and irq_o is low. Reads of unused addresses, CLR and ARM return 0.
- R2: rdata changes only on the edge that samples rd_en, and it holds its value while no read is made.
- R3: VIEW bit n returns the synchronised level of line n ANDed with VIEW_EN bit n. Writes to VIEW, RAW and PEND have no effect.
- R4: POL bit n = 1 selects active-high detection and 0 selects active-low. RAW bit n sets only when the synchronised level equals POL bit n at the end of an armed window.
- R5: A line that was never armed never sets RAW, even while its level matches its polarity.
- R6: Config bits 11:0 give the window length in millisecond ticks. The level is sampled only when the window ends, so a change during the window that is undone before the end, or a change that persists to the end, is judged only by the final level. Config bits 15:12 are stored and read back unchanged.
- R7: A window length of 0 samples the level on the second edge after the edge that captures the ARM write. A read sampled on the third edge returns the bit set, and reads on the first and second edges return it clear.
- R8: A RAW bit stays set when its level changes. Writing 1 to CLR bit n clears RAW bit n two edges after the write. Zero bits in a CLR write have no effect.
- R9: PEND equals RAW AND IRQ_EN. irq_o is the registered OR of PEND and goes high two edges after a matching IRQ_EN write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | 16 | Asynchronous interrupt lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
The detection path is tested with four kinds of line behaviour. The first is a line whose level matches its polarity but is never armed, which tells gated latching apart from free-running detection. The second arms three lines at once with mixed polarities and levels, which tells active-high from active-low and matched from unmatched lines. The third uses a nonzero window on two lines, one steady and one that changes mid-window, which tells sampling at the end of the window from sampling at arm time or continuous sampling. The zero-length window is read on three consecutive cycles to pin down the exact latch edge. Clears with zero and one bits, together with level changes after latching, tell sticky status from status that follows the level.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  // Word addresses decoded by the register port
  localparam int unsigned A_VIEW   = 0;
  localparam int unsigned A_VIEWEN = 1;
  localparam int unsigned A_POL    = 5;
  localparam int unsigned A_IRQEN  = 6;
  localparam int unsigned A_RAW    = 7;
  localparam int unsigned A_PEND   = 8;
  localparam int unsigned A_CLR    = 9;
  localparam int unsigned A_ARM    = 10;
  localparam int unsigned A_CFG    = 16;
  // Width of the debounce length field in each config word
  localparam int unsigned DBNC_W   = 12;
endpackage

// File: rtl/lvl_irq_tick.sv
module lvl_irq_tick #(
  parameter int unsigned DIV = 100000
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(DIV > 1 ? DIV : 2);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      tick_o <= 1'b0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt    <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt    <= cnt + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/lvl_irq_chan.sv
module lvl_irq_chan #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_i,
  input  logic             arm_i,
  input  logic             clr_i,
  input  logic             pol_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] dbnc_i,
  output logic             level_o,
  output logic             raw_o
);
  logic             s1;
  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic             done;

  // Window ends on the first cycle the loaded count is found at zero
  always_comb done = armed && !arm_i && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1      <= 1'b0;
      level_o <= 1'b0;
    end else begin
      s1      <= pin_i;
      level_o <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (arm_i) begin
      armed <= 1'b1;
      cnt   <= dbnc_i;
    end else if (done) begin
      armed <= 1'b0;
    end else if (armed && tick_i) begin
      cnt   <= cnt - 1'b1;
    end
  end

  // A new match takes priority over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst)                          raw_o <= 1'b0;
    else if (done && level_o == pol_i) raw_o <= 1'b1;
    else if (clr_i)                   raw_o <= 1'b0;
  end
endmodule

// File: rtl/lvl_irq_bank.sv
module lvl_irq_bank
  import lvl_irq_pkg::*;
#(
  parameter int unsigned DW       = 16,
  parameter int unsigned AW       = 6,
  parameter int unsigned TICK_DIV = 100000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] pins_i,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq_o
);
  localparam int unsigned NCH  = DW;
  localparam int unsigned CH_W = $clog2(NCH);

  logic [DW-1:0] view_en_q, pol_q, ie_q, arm_q, clr_q;
  logic [DW-1:0] lvl_w, raw_w;
  logic [DW-1:0] cfg_q [NCH];
  logic          tick;
  logic [AW-1:0] cfg_off;
  logic          cfg_hit;
  logic [CH_W-1:0] cfg_idx;

  always_comb begin
    cfg_off = addr - AW'(A_CFG);
    cfg_hit = (addr >= AW'(A_CFG)) && (cfg_off < AW'(NCH));
    cfg_idx = cfg_off[CH_W-1:0];
  end

  lvl_irq_tick #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    lvl_irq_chan #(.CNT_W(DBNC_W)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .pin_i   (pins_i[g]),
      .arm_i   (arm_q[g]),
      .clr_i   (clr_q[g]),
      .pol_i   (pol_q[g]),
      .tick_i  (tick),
      .dbnc_i  (cfg_q[g][DBNC_W-1:0]),
      .level_o (lvl_w[g]),
      .raw_o   (raw_w[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      view_en_q <= '0;
      pol_q     <= '0;
      ie_q      <= '0;
      arm_q     <= '0;
      clr_q     <= '0;
    end else begin
      arm_q <= '0;
      clr_q <= '0;
      if (wr_en) begin
        case (addr)
          AW'(A_VIEWEN): view_en_q <= wdata;
          AW'(A_POL):    pol_q     <= wdata;
          AW'(A_IRQEN):  ie_q      <= wdata;
          AW'(A_CLR):    clr_q     <= wdata;
          AW'(A_ARM):    arm_q     <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) cfg_q[i] <= '0;
    end else if (wr_en && cfg_hit) begin
      cfg_q[cfg_idx] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (cfg_hit) begin
        rdata <= cfg_q[cfg_idx];
      end else begin
        case (addr)
          AW'(A_VIEW):   rdata <= lvl_w & view_en_q;
          AW'(A_VIEWEN): rdata <= view_en_q;
          AW'(A_POL):    rdata <= pol_q;
          AW'(A_IRQEN):  rdata <= ie_q;
          AW'(A_RAW):    rdata <= raw_w;
          AW'(A_PEND):   rdata <= raw_w & ie_q;
          default:       rdata <= '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(raw_w & ie_q);
  end
endmodule

// File: rtl/lvl_irq_bank_chk.sv
module lvl_irq_bank_chk
  import lvl_irq_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] rdata,
  input logic          irq_o,
  input logic [DW-1:0] raw_vec,
  input logic [DW-1:0] ie_vec,
  input logic [DW-1:0] view_vec
);
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ($past(raw_vec) != '0)); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    ($past(ie_vec) == '0) |-> !irq_o); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata)); // R2
  AST_RAW_DROP_NEEDS_CLR: assert property (@(posedge clk) disable iff (rst)
    ((~raw_vec & $past(raw_vec)) != '0) |-> $past(wr_en && addr == AW'(A_CLR), 2)); // R8
  AST_VIEW_MASKED: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == AW'(A_VIEW)) |=> ((rdata & ~$past(view_vec)) == '0)); // R3
endmodule

bind lvl_irq_bank lvl_irq_bank_chk #(.DW(DW), .AW(AW)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .addr     (addr),
  .rdata    (rdata),
  .irq_o    (irq_o),
  .raw_vec  (raw_w),
  .ie_vec   (ie_q),
  .view_vec (view_en_q)
);

// File: tb/lvl_irq_bank_tb_top.sv
module lvl_irq_bank_tb_top;
  localparam int A_VIEW = 0, A_VIEWEN = 1, A_POL = 5, A_IRQEN = 6, A_RAW = 7;
  localparam int A_PEND = 8, A_CLR = 9, A_ARM = 10, A_CFG = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] pins = 16'hA5A5;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq_o;
  logic        rd_seen = 1'b0;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  typedef struct { logic [15:0] exp; string tag; int a; } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  lvl_irq_bank #(.DW(16), .AW(6), .TICK_DIV(4)) dut_i (
    .clk(clk), .rst(rst), .pins_i(pins), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [15:0] d);
    addr = 6'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, logic [15:0] e, string tag);
    item_t it;
    it.exp = e; it.tag = tag; it.a = a;
    sb.push_back(it);
    addr = 6'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) rd_seen <= rd_en;

  // Monitor: pops one expected item for each read the design has answered
  always @(negedge clk) begin
    if (rd_seen) begin
      if (sb.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL scoreboard: actual %h expected none", rdata);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(it.tag, rdata, it.exp);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state and unused addresses
    check("R1 irq after reset", {15'd0, irq_o}, 16'h0000);
    rd(A_POL, 16'h0000, "R1 POL reset");
    rd(A_RAW, 16'h0000, "R1 RAW reset");
    rd(3, 16'h0000, "R1 unused addr 3");
    rd(40, 16'h0000, "R1 unused addr 40");
    // R3 masked view and ignored writes
    wr(A_VIEWEN, 16'h00FF);
    idle(2);
    rd(A_VIEW, 16'h00A5, "R3 view masked");
    wr(A_VIEW, 16'hFFFF);
    wr(A_RAW, 16'hFFFF);
    wr(A_PEND, 16'hFFFF);
    rd(A_VIEW, 16'h00A5, "R3 view after write");
    rd(A_RAW, 16'h0000, "R3 raw after write");
    rd(A_VIEWEN, 16'h00FF, "R1 view enable readback");
    // R5 no latch without arm (line 0 high, active-high)
    wr(A_POL, 16'h0001);
    idle(10);
    rd(A_RAW, 16'h0000, "R5 unarmed");
    // R7 zero-length window exact latch edge
    wr(A_ARM, 16'h0001);
    rd(A_RAW, 16'h0000, "R7 edge1");
    rd(A_RAW, 16'h0000, "R7 edge2");
    rd(A_RAW, 16'h0001, "R7 edge3");
    // R9 masking and interrupt output
    rd(A_PEND, 16'h0000, "R9 pend masked");
    check("R9 irq masked", {15'd0, irq_o}, 16'h0000);
    wr(A_IRQEN, 16'h0001);
    idle(2);
    check("R9 irq raised", {15'd0, irq_o}, 16'h0001);
    rd(A_PEND, 16'h0001, "R9 pend");
    // R8 sticky status and clear
    pins[0] = 1'b0;
    idle(4);
    rd(A_RAW, 16'h0001, "R8 sticky after level change");
    wr(A_CLR, 16'h0000);
    idle(1);
    rd(A_RAW, 16'h0001, "R8 zero clear bits");
    wr(A_CLR, 16'h0001);
    idle(1);
    rd(A_RAW, 16'h0000, "R8 cleared");
    idle(1);
    check("R8 irq dropped", {15'd0, irq_o}, 16'h0000);
    // R4 polarity: line0 high-active but low, line1 low-active low, line2 low-active high
    wr(A_ARM, 16'h0007);
    idle(5);
    rd(A_RAW, 16'h0002, "R4 polarity");
    rd(A_PEND, 16'h0000, "R9 pend of unenabled line");
    // R6 windowed sampling on lines 3 (steady) and 4 (changes mid-window)
    wr(A_CFG + 3, 16'hA005);
    wr(A_CFG + 4, 16'h0005);
    rd(A_CFG + 3, 16'hA005, "R6 config readback");
    wr(A_ARM, 16'h0018);
    idle(6);
    pins[4] = 1'b1;
    idle(1);
    rd(A_RAW, 16'h0002, "R6 before window end");
    idle(30);
    rd(A_RAW, 16'h000A, "R6 after window end");
    // R2 read data holds without a read
    idle(4);
    check("R2 rdata held", rdata, 16'h000A);
    idle(3);
    check("R1 scoreboard drained", 16'(sb.size()), 16'h0000);
    finish_run();
  end
endmodule